// File: doc/BRIEF.md
# DMA Channel Command and Status Controller

This block is the control face of a single DMA channel. Software writes one-hot commands into a command word to start, pause, resume, stop, disable or wipe the channel. It reads back a status word that shows both the live channel state and two latched interrupt flags. A neighbouring transfer engine moves the data. It tells this block when a beat is in flight, when the transfer has completed and when it has failed, and it gives a cause vector with each failure. In return the block grants the engine permission to move beats and pulses a start strobe at the beginning of each transfer.

The channel is an eight-state machine:
- IDLE: reset and disabled.
- RUN: transferring.
- PAUSE: suspended by software.
- STOPPING: a stop is waiting for the in-flight beat to finish.
- STOPPED: the stop is complete.
- DISABLING: a disable is waiting for the in-flight beat to finish.
- DONE: the transfer completed.
- ERROR: the transfer failed.

The named transitions are:
- start: IDLE, DONE, STOPPED or ERROR to RUN.
- suspend: RUN to PAUSE.
- continue: PAUSE to RUN.
- halt: RUN or PAUSE to STOPPING or STOPPED.
- drain-stop: STOPPING to STOPPED.
- shut: RUN or PAUSE to DISABLING or IDLE, and DONE, STOPPED or ERROR to IDLE.
- drain-shut: DISABLING to IDLE.
- finish: RUN or PAUSE to DONE.
- fault: any active state to ERROR.
- wipe: any state to IDLE.

Reads are combinational from a separate read address, so software can poll the status word while it writes commands. The interrupt line is the OR of the latched flags gated by their enables.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the state is IDLE. The status word (offset 0x04) reads only bit18 (idle/disabled) set, `irq`, `eng_go` and `eng_start` are low, and the enable word (0x08) and the cause word (0x90) read zero.
- R2: A command write (offset 0x00) with bit0 (enable) set in IDLE, DONE, STOPPED or ERROR enters RUN at the next edge. `eng_go` is high in every RUN cycle, `eng_start` is high only in the first RUN cycle, and the cause word is zeroed.
- R3: Enable is ignored in RUN, PAUSE, STOPPING and DISABLING.
- R4: Pause (bit4) is honoured only in RUN and enters PAUSE. Resume (bit5) is honoured only in PAUSE and returns to RUN. In PAUSE, status bit21 (resume-wait) is set, and bit20 (paused) is set only while `eng_busy` is low.
- R5: Stop (bit3) in RUN or PAUSE enters STOPPED (status bit19) directly if `eng_busy` is low, and otherwise enters STOPPING until `eng_busy` falls. A done event in STOPPING sets no flag.
- R6: Disable (bit2) in RUN or PAUSE goes to IDLE, through DISABLING while `eng_busy` is high. In DONE, STOPPED or ERROR it goes to IDLE at the next edge.
- R7: Clear (bit1) in any state returns to IDLE at the next edge and zeroes the flags, the enable word and the cause word.
- R8: When a command write sets several bits, only the highest-ranked one is considered: clear, then disable, stop, pause, resume, enable. If that command does not apply in the current state, the write has no effect.
- R9: A done event in RUN or PAUSE enters DONE (status bit16) and sets the done flag (status bit0).
- R10: An error event in RUN, PAUSE, STOPPING or DISABLING enters ERROR (status bit17) and sets the error flag (status bit1). It also ORs `eng_err_cause` into the cause word: index 0 read response to bit16, index 1 write response to bit17, index 2 read poison to bit18. Error wins over a done event in the same cycle.
- R11: An engine event in the same cycle as any command other than clear wins, and the command is dropped.
- R12: Writing ones to bits 0 and 1 of the status word clears the matching flags. A flag being set in the same cycle stays set.
- R13: The enable word (0x08) bit0 gates done and bit1 gates error. `irq` is high exactly when an enabled flag is set.
- R14: Done and error events in IDLE, DONE, STOPPED and ERROR change neither the state, the flags nor the cause word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | DATA_W | Register read data, combinational |
| eng_busy | input | 1 | A beat is in flight in the engine |
| eng_done | input | 1 | Transfer completed (one-cycle event) |
| eng_err | input | 1 | Transfer failed (one-cycle event) |
| eng_err_cause | input | NUM_CAUSES | Failure cause bits, valid with `eng_err` |
| eng_go | output | 1 | Engine may issue beats |
| eng_start | output | 1 | First cycle of a new transfer |
| irq | output | 1 | Channel interrupt |

## Verification
Software commands and engine events can land on the same clock edge, so the bench puts the two into the same cycle on purpose:
- pause together with done;
- a status write-one-to-clear together with a new done;
- done together with error;
- clear together with an error.

A behavioural model in the bench resolves each collision by the stated precedence and is compared every cycle with the state, the flags and the outputs. Busy-gated stop and disable are also driven with `eng_busy` held high and then released, so that both the direct path and the draining path are judged.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_RUN,
        CH_PAUSE,
        CH_STOPPING,
        CH_STOPPED,
        CH_DISABLING,
        CH_DONE,
        CH_ERROR
    } ch_state_e;

    // command word bit positions (software-visible encoding)
    localparam int NUM_CMDS    = 6;
    localparam int CMD_ENABLE  = 0;
    localparam int CMD_CLEAR   = 1;
    localparam int CMD_DISABLE = 2;
    localparam int CMD_STOP    = 3;
    localparam int CMD_PAUSE   = 4;
    localparam int CMD_RESUME  = 5;

    // ranking, highest first
    localparam int CMD_RANK [NUM_CMDS] = '{CMD_CLEAR, CMD_DISABLE, CMD_STOP,
                                           CMD_PAUSE, CMD_RESUME, CMD_ENABLE};

    // register offsets
    localparam int OFF_CMD    = 'h00;
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_IEN    = 'h08;
    localparam int OFF_CAUSE  = 'h90;

    // interrupt sources
    localparam int NUM_IRQ_SRC = 2;
    localparam int IRQ_DONE    = 0;
    localparam int IRQ_ERR     = 1;

    // status word level bits
    localparam int STB_DONE    = 16;
    localparam int STB_ERROR   = 17;
    localparam int STB_IDLE    = 18;
    localparam int STB_STOPPED = 19;
    localparam int STB_PAUSED  = 20;
    localparam int STB_RWAIT   = 21;

    // cause field
    localparam int NUM_CAUSES = 3;
    localparam int CAUSE_LSB  = 16;

endpackage

// File: rtl/dmacc_cmd_dec.sv
module dmacc_cmd_dec
    import dmacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CMDS-1:0] cmd_sel
);

    logic cmd_wr;
    logic hit;

    assign cmd_wr = wr_en && (wr_addr == ADDR_W'(OFF_CMD));

    // keep only the highest-ranked command bit of the write
    always_comb begin
        cmd_sel = '0;
        hit     = 1'b0;
        for (int k = 0; k < NUM_CMDS; k++) begin
            if (cmd_wr && !hit && wr_data[CMD_RANK[k]]) begin
                cmd_sel[CMD_RANK[k]] = 1'b1;
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmacc_fsm.sv
module dmacc_fsm
    import dmacc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CMDS-1:0] cmd_sel,
    input  logic                eng_busy,
    input  logic                eng_done,
    input  logic                eng_err,
    output ch_state_e           st_q,
    output logic                acc_done,
    output logic                acc_err,
    output logic                acc_enable,
    output logic                eng_go
);

    ch_state_e st_d;
    logic      live;
    logic      draining;

    assign live     = (st_q == CH_RUN) || (st_q == CH_PAUSE);
    assign draining = (st_q == CH_STOPPING) || (st_q == CH_DISABLING);

    always_comb begin
        st_d = st_q;
        if (cmd_sel[CMD_CLEAR]) begin
            st_d = CH_IDLE;                                   // wipe
        end else if ((live || draining) && eng_err) begin
            st_d = CH_ERROR;                                  // fault
        end else if (live && eng_done) begin
            st_d = CH_DONE;                                   // finish
        end else begin
            unique case (st_q)
                CH_IDLE, CH_DONE, CH_STOPPED, CH_ERROR: begin
                    if (cmd_sel[CMD_DISABLE])
                        st_d = CH_IDLE;                       // shut
                    else if (cmd_sel[CMD_ENABLE])
                        st_d = CH_RUN;                        // start
                end
                CH_RUN, CH_PAUSE: begin
                    if (cmd_sel[CMD_DISABLE])
                        st_d = eng_busy ? CH_DISABLING : CH_IDLE;
                    else if (cmd_sel[CMD_STOP])
                        st_d = eng_busy ? CH_STOPPING : CH_STOPPED;
                    else if (cmd_sel[CMD_PAUSE] && st_q == CH_RUN)
                        st_d = CH_PAUSE;                      // suspend
                    else if (cmd_sel[CMD_RESUME] && st_q == CH_PAUSE)
                        st_d = CH_RUN;                        // continue
                end
                CH_STOPPING: begin
                    if (!eng_busy) st_d = CH_STOPPED;         // drain-stop
                end
                CH_DISABLING: begin
                    if (!eng_busy) st_d = CH_IDLE;            // drain-shut
                end
                default: st_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        acc_done   = (st_d == CH_DONE)  && (st_q != CH_DONE);
        acc_err    = (st_d == CH_ERROR) && (st_q != CH_ERROR);
        acc_enable = (st_d == CH_RUN) && !live;
        eng_go     = (st_q == CH_RUN);
    end

endmodule

// File: rtl/dmacc_regs.sv
module dmacc_regs
    import dmacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  ch_state_e             st_q,
    input  logic                  do_clear,
    input  logic                  acc_done,
    input  logic                  acc_err,
    input  logic                  acc_enable,
    input  logic                  eng_busy,
    input  logic [NUM_CAUSES-1:0] eng_err_cause,
    output logic [NUM_IRQ_SRC-1:0] intr_q,
    output logic [NUM_IRQ_SRC-1:0] ien_q,
    output logic                  eng_start,
    output logic                  irq
);

    logic [NUM_CAUSES-1:0]  cause_q;
    logic [NUM_IRQ_SRC-1:0] set_v;
    logic                   w1c_wr;
    logic                   ien_wr;
    logic [DATA_W-1:0]      status_word;
    logic [DATA_W-1:0]      cause_word;
    logic [DATA_W-1:0]      ien_word;

    assign w1c_wr = wr_en && (wr_addr == ADDR_W'(OFF_STATUS));
    assign ien_wr = wr_en && (wr_addr == ADDR_W'(OFF_IEN));

    always_comb begin
        set_v           = '0;
        set_v[IRQ_DONE] = acc_done;
        set_v[IRQ_ERR]  = acc_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_q <= '0;
        end else begin
            for (int i = 0; i < NUM_IRQ_SRC; i++) begin
                if (do_clear)                    intr_q[i] <= 1'b0;
                else if (set_v[i])               intr_q[i] <= 1'b1;
                else if (w1c_wr && wr_data[i])   intr_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ien_q <= '0;
        else if (do_clear) ien_q <= '0;
        else if (ien_wr)   ien_q <= wr_data[NUM_IRQ_SRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cause_q <= '0;
        else if (do_clear || acc_enable)  cause_q <= '0;
        else if (acc_err)                 cause_q <= cause_q | eng_err_cause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_start <= 1'b0;
        else        eng_start <= acc_enable;
    end

    assign irq = |(intr_q & ien_q);

    // read words
    always_comb begin
        status_word                          = '0;
        status_word[NUM_IRQ_SRC-1:0]         = intr_q;
        status_word[STB_DONE]                = (st_q == CH_DONE);
        status_word[STB_ERROR]               = (st_q == CH_ERROR);
        status_word[STB_IDLE]                = (st_q == CH_IDLE);
        status_word[STB_STOPPED]             = (st_q == CH_STOPPED);
        status_word[STB_PAUSED]              = (st_q == CH_PAUSE) && !eng_busy;
        status_word[STB_RWAIT]               = (st_q == CH_PAUSE);
        cause_word                           = '0;
        cause_word[CAUSE_LSB +: NUM_CAUSES]  = cause_q;
        ien_word                             = '0;
        ien_word[NUM_IRQ_SRC-1:0]            = ien_q;
    end

    always_comb begin
        if (rd_addr == ADDR_W'(OFF_STATUS))      rd_data = status_word;
        else if (rd_addr == ADDR_W'(OFF_IEN))    rd_data = ien_word;
        else if (rd_addr == ADDR_W'(OFF_CAUSE))  rd_data = cause_word;
        else                                     rd_data = '0;
    end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dmacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  eng_busy,
    input  logic                  eng_done,
    input  logic                  eng_err,
    input  logic [NUM_CAUSES-1:0] eng_err_cause,
    output logic                  eng_go,
    output logic                  eng_start,
    output logic                  irq
);

    logic [NUM_CMDS-1:0]    cmd_sel;
    ch_state_e              st_q;
    logic                   acc_done;
    logic                   acc_err;
    logic                   acc_enable;
    logic [NUM_IRQ_SRC-1:0] intr_q;
    logic [NUM_IRQ_SRC-1:0] ien_q;

    dmacc_cmd_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd_sel (cmd_sel)
    );

    dmacc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_sel    (cmd_sel),
        .eng_busy   (eng_busy),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .st_q       (st_q),
        .acc_done   (acc_done),
        .acc_err    (acc_err),
        .acc_enable (acc_enable),
        .eng_go     (eng_go)
    );

    dmacc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .st_q          (st_q),
        .do_clear      (cmd_sel[CMD_CLEAR]),
        .acc_done      (acc_done),
        .acc_err       (acc_err),
        .acc_enable    (acc_enable),
        .eng_busy      (eng_busy),
        .eng_err_cause (eng_err_cause),
        .intr_q        (intr_q),
        .ien_q         (ien_q),
        .eng_start     (eng_start),
        .irq           (irq)
    );

endmodule

// File: rtl/dmacc_checker.sv
module dmacc_checker
    import dmacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [DATA_W-1:0]      wr_data,
    input logic                   eng_done,
    input logic                   eng_err,
    input logic                   eng_go,
    input logic                   eng_start,
    input logic                   irq,
    input ch_state_e              st,
    input logic [NUM_IRQ_SRC-1:0] flags,
    input logic [NUM_IRQ_SRC-1:0] ien
);

    logic cmd_wr;
    logic clr;
    assign cmd_wr = wr_en && (wr_addr == ADDR_W'(OFF_CMD));
    assign clr    = cmd_wr && wr_data[CMD_CLEAR];

    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> eng_go);

    a_r4_pause_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_PAUSE && $past(st) != CH_PAUSE) |-> $past(st) == CH_RUN);

    a_r5_stopping_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == CH_STOPPING) |-> !(flags[IRQ_DONE] && !$past(flags[IRQ_DONE])));

    a_r7_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st == CH_IDLE && flags == '0 && ien == '0));

    a_r10_error_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN && eng_err && eng_done && !clr) |=> st == CH_ERROR);

    a_r13_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != '0));

    a_r14_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_IDLE && !cmd_wr) |=> st == CH_IDLE);

endmodule

bind dma_chan_ctl dmacc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .eng_go    (eng_go),
    .eng_start (eng_start),
    .irq       (irq),
    .st        (st_q),
    .flags     (intr_q),
    .ien       (ien_q)
);

// File: tb/sim_dma_chan_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctl;

    localparam int S_IDLE = 0, S_RUN = 1, S_PAUSE = 2, S_STOPPING = 3,
                   S_STOPPED = 4, S_DISABLING = 5, S_DONE = 6, S_ERR = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h04;
    logic [31:0] rd_data;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic [2:0]  eng_err_cause = '0;
    logic        eng_go;
    logic        eng_start;
    logic        irq;

    always #4 clk = ~clk;

    dma_chan_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
        .eng_err_cause(eng_err_cause), .eng_go(eng_go),
        .eng_start(eng_start), .irq(irq)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    n_tick = 0;
    bit    ended = 0;
    string cur_req = "R1";

    // reference model
    int       m_st = S_IDLE;
    bit [1:0] m_flag = '0;
    bit [1:0] m_ien = '0;
    bit [2:0] m_cause = '0;
    bit       m_start = 0;

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        logic [31:0] w = '0;
        case (a)
            8'h04: begin
                w[1:0] = m_flag;
                w[16]  = (m_st == S_DONE);
                w[17]  = (m_st == S_ERR);
                w[18]  = (m_st == S_IDLE);
                w[19]  = (m_st == S_STOPPED);
                w[20]  = (m_st == S_PAUSE) && !eng_busy;
                w[21]  = (m_st == S_PAUSE);
            end
            8'h08: w[1:0] = m_ien;
            8'h90: w[18:16] = m_cause;
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic mdl_update();
        int c = -1;
        int nst = m_st;
        bit sd = 0, se = 0, ge = 0, act, drn;
        bit wc;
        if (!rst_n) begin
            m_st = S_IDLE; m_flag = '0; m_ien = '0; m_cause = '0; m_start = 0;
            return;
        end
        if (wr_en && wr_addr == 8'h00) begin
            if (wr_data[1])      c = 1;
            else if (wr_data[2]) c = 2;
            else if (wr_data[3]) c = 3;
            else if (wr_data[4]) c = 4;
            else if (wr_data[5]) c = 5;
            else if (wr_data[0]) c = 0;
        end
        wc  = wr_en && wr_addr == 8'h04;
        act = (m_st == S_RUN) || (m_st == S_PAUSE);
        drn = (m_st == S_STOPPING) || (m_st == S_DISABLING);
        if (c == 1) nst = S_IDLE;
        else if ((act || drn) && eng_err) begin nst = S_ERR; se = 1; end
        else if (act && eng_done) begin nst = S_DONE; sd = 1; end
        else if (m_st == S_STOPPING) begin if (!eng_busy) nst = S_STOPPED; end
        else if (m_st == S_DISABLING) begin if (!eng_busy) nst = S_IDLE; end
        else if (act) begin
            if (c == 2)                           nst = eng_busy ? S_DISABLING : S_IDLE;
            else if (c == 3)                      nst = eng_busy ? S_STOPPING : S_STOPPED;
            else if (c == 4 && m_st == S_RUN)     nst = S_PAUSE;
            else if (c == 5 && m_st == S_PAUSE)   nst = S_RUN;
        end else begin
            if (c == 2)      nst = S_IDLE;
            else if (c == 0) begin nst = S_RUN; ge = 1; end
        end
        if (c == 1) begin
            m_flag = '0; m_ien = '0; m_cause = '0;
        end else begin
            if (sd) m_flag[0] = 1; else if (wc && wr_data[0]) m_flag[0] = 0;
            if (se) m_flag[1] = 1; else if (wc && wr_data[1]) m_flag[1] = 0;
            if (wr_en && wr_addr == 8'h08) m_ien = wr_data[1:0];
            if (ge) m_cause = '0;
            else if (se) m_cause = m_cause | eng_err_cause;
        end
        m_start = ge;
        m_st = nst;
    endtask

    task automatic tick();
        @(posedge clk);
        mdl_update();
        #2;
        check("irq", {31'd0, irq}, {31'd0, |(m_flag & m_ien)});
        check("eng_go", {31'd0, eng_go}, {31'd0, m_st == S_RUN});
        check("eng_start", {31'd0, eng_start}, {31'd0, m_start});
        check($sformatf("rd[%h]", rd_addr), rd_data, exp_read(rd_addr));
        n_tick++;
        case (n_tick % 4)
            2: rd_addr = 8'h08;
            3: rd_addr = 8'h90;
            default: rd_addr = 8'h04;
        endcase
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0; wr_data = '0;
    endtask

    task automatic ev(bit d, bit e, logic [2:0] cause);
        eng_done = d; eng_err = e; eng_err_cause = cause;
        tick();
        eng_done = 0; eng_err = 0; eng_err_cause = '0;
    endtask

    task automatic idle_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL %s watchdog expired", cur_req);
        finish_run();
    end

    initial begin
        cur_req = "R1";               // reset state
        idle_n(3);
        rst_n = 1;
        idle_n(4);

        cur_req = "R13";              // enable gating of irq
        wr(8'h08, 32'h3);
        idle_n(2);

        cur_req = "R2";               // enable from idle
        wr(8'h00, 32'h01);
        eng_busy = 1; idle_n(3); eng_busy = 0; idle_n(2);

        cur_req = "R3";               // enable while running ignored
        wr(8'h00, 32'h01);
        idle_n(2);

        cur_req = "R4";               // pause / resume
        wr(8'h00, 32'h20);            // resume in run ignored
        eng_busy = 1;
        wr(8'h00, 32'h10);
        idle_n(2);
        eng_busy = 0; idle_n(2);
        wr(8'h00, 32'h10);            // pause in pause ignored
        cur_req = "R3";
        wr(8'h00, 32'h01);            // enable in pause ignored
        cur_req = "R4";
        wr(8'h00, 32'h20);
        idle_n(2);

        cur_req = "R9";               // done event
        ev(1, 0, 3'b000);
        idle_n(3);

        cur_req = "R12";              // W1C
        wr(8'h04, 32'h1);
        idle_n(2);

        cur_req = "R14";              // events outside active states ignored
        ev(1, 1, 3'b111);
        idle_n(2);

        cur_req = "R12";              // set wins over clear in same cycle
        wr(8'h00, 32'h01);
        idle_n(2);
        wr_en = 1; wr_addr = 8'h04; wr_data = 32'h1; eng_done = 1;
        tick();
        wr_en = 0; eng_done = 0; wr_data = '0;
        idle_n(2);
        wr(8'h04, 32'h3);

        cur_req = "R10";              // error beats done, cause bits latched
        wr(8'h00, 32'h01);
        idle_n(1);
        ev(1, 1, 3'b101);
        idle_n(4);
        wr(8'h04, 32'h2);

        cur_req = "R5";               // stop with beat in flight, done ignored
        wr(8'h00, 32'h01);
        eng_busy = 1;
        wr(8'h00, 32'h08);
        idle_n(2);
        ev(1, 0, 3'b000);
        eng_busy = 0;
        idle_n(3);
        wr(8'h00, 32'h01);            // restart from stopped
        wr(8'h00, 32'h08);            // direct stop
        idle_n(2);

        cur_req = "R10";              // error during stopping
        wr(8'h00, 32'h01);
        eng_busy = 1;
        wr(8'h00, 32'h08);
        ev(0, 1, 3'b010);
        eng_busy = 0;
        idle_n(3);

        cur_req = "R6";               // disable from error, then while busy
        wr(8'h00, 32'h04);
        idle_n(2);
        wr(8'h00, 32'h01);
        eng_busy = 1;
        wr(8'h00, 32'h04);
        idle_n(3);
        eng_busy = 0;
        idle_n(2);
        wr(8'h00, 32'h01);
        wr(8'h00, 32'h04);            // direct disable
        idle_n(2);

        cur_req = "R8";               // stop beats pause; disable beats enable
        wr(8'h00, 32'h01);
        wr(8'h00, 32'h18);
        idle_n(2);
        wr(8'h00, 32'h05);
        idle_n(2);
        wr(8'h00, 32'h11);            // pause ranks above enable, not applicable
        idle_n(2);

        cur_req = "R11";              // event wins over command
        wr(8'h00, 32'h01);
        wr_en = 1; wr_addr = 8'h00; wr_data = 32'h10; eng_done = 1;
        tick();
        wr_en = 0; eng_done = 0; wr_data = '0;
        idle_n(3);
        wr(8'h00, 32'h01);
        wr_en = 1; wr_addr = 8'h00; wr_data = 32'h08; eng_err = 1; eng_err_cause = 3'b001;
        tick();
        wr_en = 0; eng_err = 0; eng_err_cause = '0; wr_data = '0;
        idle_n(3);

        cur_req = "R7";               // clear wins over error, wipes everything
        wr(8'h00, 32'h01);
        wr_en = 1; wr_addr = 8'h00; wr_data = 32'h02; eng_err = 1; eng_err_cause = 3'b100;
        tick();
        wr_en = 0; eng_err = 0; eng_err_cause = '0; wr_data = '0;
        idle_n(4);

        cur_req = "R13";              // only done enabled
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h01);
        ev(0, 1, 3'b011);
        idle_n(3);
        wr(8'h00, 32'h01);
        ev(1, 0, 3'b000);
        idle_n(3);
        wr(8'h08, 32'h0);
        idle_n(3);

        finish_run();
    end

endmodule